// File: doc/BRIEF.md
# Multi-mode timer waveform generator

This block is a free-running timer that drives four compare channels and an overflow pulse. A 3-bit mode input chooses among several operations:

- frequency generation, with the top taken from the period register or from compare channel 0;
- single-slope PWM;
- four dual-slope PWM variants.

The mode decides four things: the count at which the counter turns or wraps, the instants at which buffered period and compare values become active, how each channel reacts to a compare match, and where the overflow pulse fires.

The host writes the period and compare buffers through write strobes. It sets the per-channel polarity, the circular-buffer enables and the output-pair swap enables as static controls. In single-slope modes a separate input chooses up or down counting. Dual-slope modes turn around by themselves at top and at zero.

Top module: `wavegen_timer`

## Requirements
- R1: After synchronous active-low reset the counter is 0 and counts upward, all channel outputs and the overflow pulse are low, the active period is all ones and every active compare value is 0.
- R2: Mode code 1 takes the top from active compare value 0. Every other running mode (codes 0, 2, 4, 5, 6 and 7) takes the top from the active period.
- R3: In modes 0 and 1 a channel output inverts on each clock edge at which the counter equals that channel's compare value. An update leaves the outputs unchanged.
- R4: In modes 0, 1 and 2 with the direction input low, the counter counts up and wraps from top to 0. With the direction input high it counts down and reloads top after 0. The wrap or reload edge is an update, and the overflow output is high for the one cycle after it.
- R5: In mode 2, call the direction input D. At an update, a channel with polarity 0 goes to not-D and a channel with polarity 1 goes to D. On a match the channel goes to the opposite level. When match and update fall on the same edge, the update level wins.
- R6: In modes 4 to 7 the counter runs 0 up to top, then down to 0, then up again. On a match, a channel with polarity 0 goes to the inverse of the current direction (1 = counting down), and a channel with polarity 1 goes to the direction itself. Updates leave the outputs unchanged.
- R7: Updates occur at zero in modes 4, 5 and 7, and at both top and zero in mode 6. The overflow pulse follows at zero in modes 4 and 5, at top and zero in mode 6, and at top only in mode 7.
- R8: A strobe on the period or compare write input stores the data in that buffer and marks it valid. At an update, a valid buffer is copied into the active register and its valid mark is cleared, so an unwritten buffer is not loaded again.
- R9: With a circular enable set for the period or for a compare channel, every update exchanges that buffer with its active register, whether or not the buffer is valid.
- R10: Swap enable bit x exchanges output x with output x+2 at the pins. With swap bit x clear, both of those outputs pass straight through.
- R11: Mode code 3 stops the counter, suppresses the overflow pulse and, one edge later, drives each channel to its polarity bit, whatever the enable input is.
- R12: With the enable input low in any mode other than 3, the counter, the channel outputs and the overflow pulse (held low) do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable for the counter |
| mode | input | 3 | Operation select, codes 0 to 7 |
| count_down | input | 1 | Single-slope count direction, 1 = down |
| pol | input | NUM_CH | Per-channel polarity |
| circ_per_en | input | 1 | Circular operation of the period buffer |
| circ_cc_en | input | NUM_CH | Circular operation of each compare buffer |
| swap_en | input | NUM_CH/2 | Output pair swap enables |
| per_buf_wr | input | 1 | Period buffer write strobe |
| per_buf_data | input | CNT_W | Period buffer write data |
| cc_buf_wr | input | NUM_CH | Compare buffer write strobes |
| cc_buf_data | input | NUM_CH*CNT_W | Compare buffer write data, channel i in bits i*CNT_W upward |
| wave_o | output | NUM_CH | Waveform outputs after pair swap |
| ovf_o | output | 1 | Overflow pulse |

## Verification
The counter value, each channel level and the overflow pulse are all registered. Each takes its new value at the edge that sees the counter at the match, top or zero count, and is visible from the following cycle. The pair swap is the only combinational path, so it shows at the pins in the same cycle as the channel levels it routes. The bench changes inputs on a falling edge and counts rising edges from that point. From the counter's known starting value it works out the edge at which every match and turnaround happens, and it samples on the falling edge just after that edge. Between the phases of the test, mode 3 parks the counter at a known value so that each phase starts from a defined state.

// File: rtl/wavegen_pkg.sv
// Package: shared mode encoding for the waveform timer.
// Assumes: the mode port carries exactly these 3-bit codes.
package wavegen_pkg;

    typedef enum logic [2:0] {
        WG_NFRQ    = 3'd0,
        WG_MFRQ    = 3'd1,
        WG_NPWM    = 3'd2,
        WG_RSVD    = 3'd3,
        WG_DS_CRIT = 3'd4,
        WG_DS_BOT  = 3'd5,
        WG_DS_BOTH = 3'd6,
        WG_DS_TOP  = 3'd7
    } wg_mode_e;

endpackage

// File: rtl/wg_counter.sv
// Module: timer counter with single-slope and dual-slope sequencing.
// Single slope: the direction comes from count_down; up wraps top->0,
// down reloads top after 0. Dual slope: internal direction, turning
// at top and at zero. The at_top/at_zero flags are qualified by run.
// Assumes: top may change at any time; counting up past top wraps.
module wg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dual,
    input  logic             count_down,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             at_top_o,
    output logic             at_zero_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             going_down;

    // Effective direction: dual slope uses its own state.
    assign going_down = dual ? dir_q : count_down;
    assign at_top_o   = run && !going_down && (cnt_q >= top);
    assign at_zero_o  = run && going_down && (cnt_q == '0);
    assign cnt_o      = cnt_q;
    assign dir_o      = going_down;

    // Counter and dual-slope direction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (run) begin
            if (!dual) begin
                dir_q <= 1'b0;
                if (at_top_o)       cnt_q <= '0;
                else if (at_zero_o) cnt_q <= top;
                else if (count_down) cnt_q <= cnt_q - CNT_ONE;
                else                cnt_q <= cnt_q + CNT_ONE;
            end else begin
                if (at_top_o) begin
                    cnt_q <= (top == '0) ? '0 : top - CNT_ONE;
                    dir_q <= (top != '0);
                end else if (at_zero_o) begin
                    cnt_q <= (top == '0) ? '0 : CNT_ONE;
                    dir_q <= 1'b0;
                end else begin
                    cnt_q <= dir_q ? cnt_q - CNT_ONE : cnt_q + CNT_ONE;
                end
            end
        end
    end

endmodule

// File: rtl/wg_buffer.sv
// Module: buffered register (active value plus host buffer).
// A write stores data in the buffer and marks it valid. At an update
// the active value takes the buffer when valid, or always when circular
// is set; circular also moves the old active value into the buffer.
// Assumes: a write in the same cycle as an update wins in the buffer.
module wg_buffer #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         upd,
    input  logic         circ,
    output logic [W-1:0] active_o
);

    logic [W-1:0] act_q;
    logic [W-1:0] buf_q;
    logic         vld_q;
    logic         load;

    assign load     = upd && (vld_q || circ);
    assign active_o = act_q;

    // Active, buffer and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= INIT;
            buf_q <= '0;
            vld_q <= 1'b0;
        end else begin
            if (load) act_q <= buf_q;
            if (wr) begin
                buf_q <= wr_data;
                vld_q <= 1'b1;
            end else if (load) begin
                vld_q <= 1'b0;
                if (circ) buf_q <= act_q;
            end
        end
    end

endmodule

// File: rtl/wg_channel.sv
// Module: one compare channel output level.
// Frequency kind toggles on match. Single-slope PWM goes to the
// start level on update (update wins) and to the opposite on match.
// Dual slope drives on match from direction and polarity. Idle forces
// the polarity level.
// Assumes: exactly one of the kind flags is set while running.
module wg_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic idle,
    input  logic is_freq,
    input  logic is_npwm,
    input  logic is_dual,
    input  logic pol,
    input  logic dir,
    input  logic match,
    input  logic upd,
    output logic level_o
);

    logic lvl_q;

    assign level_o = lvl_q;

    // Output level update per operation kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (idle) begin
            lvl_q <= pol;
        end else if (run) begin
            if (is_freq) begin
                if (match) lvl_q <= !lvl_q;
            end else if (is_npwm) begin
                if (upd)        lvl_q <= pol ? dir : !dir;
                else if (match) lvl_q <= pol ? !dir : dir;
            end else if (is_dual) begin
                if (match) lvl_q <= pol ? dir : !dir;
            end
        end
    end

endmodule

// File: rtl/wg_swap.sv
// Module: output pair exchange, output x with output x+NUM_CH/2.
// Assumes: NUM_CH is even.
module wg_swap #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0]   in_i,
    input  logic [NUM_CH/2-1:0] swap_en,
    output logic [NUM_CH-1:0]   out_o
);

    localparam int HALF = NUM_CH / 2;

    for (genvar i = 0; i < HALF; i++) begin : g_pair
        assign out_o[i]      = swap_en[i] ? in_i[i + HALF] : in_i[i];
        assign out_o[i+HALF] = swap_en[i] ? in_i[i] : in_i[i + HALF];
    end

endmodule

// File: rtl/wavegen_timer.sv
// Module: multi-mode timer waveform generator (top).
// Decodes the mode into the top source, update and overflow points and
// the channel kind, then ties together the counter, buffers, channels
// and pair swap. The overflow pulse is registered.
// Assumes: static controls come from the same clock domain.
module wavegen_timer #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [2:0]              mode,
    input  logic                    count_down,
    input  logic [NUM_CH-1:0]       pol,
    input  logic                    circ_per_en,
    input  logic [NUM_CH-1:0]       circ_cc_en,
    input  logic [NUM_CH/2-1:0]     swap_en,
    input  logic                    per_buf_wr,
    input  logic [CNT_W-1:0]        per_buf_data,
    input  logic [NUM_CH-1:0]       cc_buf_wr,
    input  logic [NUM_CH*CNT_W-1:0] cc_buf_data,
    output logic [NUM_CH-1:0]       wave_o,
    output logic                    ovf_o
);

    import wavegen_pkg::*;

    localparam logic [CNT_W-1:0] PER_INIT = '1;

    wg_mode_e         mode_e;
    logic             idle, run, dual, is_freq, is_npwm;
    logic             at_top, at_zero, upd, ovf_ev, ovf_q, cnt_dir;
    logic [CNT_W-1:0] cnt, top_val, per_act;
    logic [CNT_W-1:0] cc_act [NUM_CH];
    logic [NUM_CH-1:0] wave_q;

    assign mode_e  = wg_mode_e'(mode);
    assign idle    = (mode_e == WG_RSVD);
    assign run     = enable && !idle;
    assign dual    = mode[2];
    assign is_freq = (mode_e == WG_NFRQ) || (mode_e == WG_MFRQ);
    assign is_npwm = (mode_e == WG_NPWM);
    assign top_val = (mode_e == WG_MFRQ) ? cc_act[0] : per_act;
    assign ovf_o   = ovf_q;

    // Update and overflow instants per mode.
    always_comb begin
        unique case (mode_e)
            WG_NFRQ, WG_MFRQ, WG_NPWM: begin
                upd    = at_top || at_zero;
                ovf_ev = at_top || at_zero;
            end
            WG_DS_CRIT, WG_DS_BOT: begin
                upd    = at_zero;
                ovf_ev = at_zero;
            end
            WG_DS_BOTH: begin
                upd    = at_top || at_zero;
                ovf_ev = at_top || at_zero;
            end
            WG_DS_TOP: begin
                upd    = at_zero;
                ovf_ev = at_top;
            end
            default: begin
                upd    = 1'b0;
                ovf_ev = 1'b0;
            end
        endcase
    end

    // Registered overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_ev;
    end

    wg_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .dual       (dual),
        .count_down (count_down),
        .top        (top_val),
        .cnt_o      (cnt),
        .dir_o      (cnt_dir),
        .at_top_o   (at_top),
        .at_zero_o  (at_zero)
    );

    wg_buffer #(.W(CNT_W), .INIT(PER_INIT)) u_per_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (per_buf_wr),
        .wr_data  (per_buf_data),
        .upd      (upd),
        .circ     (circ_per_en),
        .active_o (per_act)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        wg_buffer #(.W(CNT_W), .INIT('0)) u_cc_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (cc_buf_wr[i]),
            .wr_data  (cc_buf_data[i*CNT_W +: CNT_W]),
            .upd      (upd),
            .circ     (circ_cc_en[i]),
            .active_o (cc_act[i])
        );

        wg_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .idle    (idle),
            .is_freq (is_freq),
            .is_npwm (is_npwm),
            .is_dual (dual),
            .pol     (pol[i]),
            .dir     (cnt_dir),
            .match   (run && (cnt == cc_act[i])),
            .upd     (upd),
            .level_o (wave_q[i])
        );
    end

    wg_swap #(.NUM_CH(NUM_CH)) u_swap (
        .in_i    (wave_q),
        .swap_en (swap_en),
        .out_o   (wave_o)
    );

endmodule

// File: rtl/wavegen_timer_chk.sv
// Module: assertion checker for wavegen_timer, attached by bind.
// Assumes: the internal counter, direction, top and channel levels are
// visible through the bind connections.
module wavegen_timer_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [2:0]        mode,
    input logic              count_down,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  top_val,
    input logic              dir,
    input logic [NUM_CH-1:0] pol,
    input logic [NUM_CH-1:0] wave_q,
    input logic              ovf_o
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == '0 && wave_q == '0 && !ovf_o));

    p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode < 3'd3 && !count_down && cnt >= top_val) |=> (cnt == '0 && ovf_o));

    p_dual_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode[2] && !dir && cnt >= top_val && top_val != '0) |=> dir);

    p_no_bottom_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == 3'd7 && dir && cnt == '0) |=> !ovf_o);

    p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |=> (wave_q == $past(pol) && $stable(cnt) && !ovf_o));

    p_hold_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && mode != 3'd3) |=> ($stable(cnt) && $stable(wave_q) && !ovf_o));

endmodule

bind wavegen_timer wavegen_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .mode       (mode),
    .count_down (count_down),
    .cnt        (cnt),
    .top_val    (top_val),
    .dir        (cnt_dir),
    .pol        (pol),
    .wave_q     (wave_q),
    .ovf_o      (ovf_o)
);

// File: tb/wavegen_timer_bench.sv
`timescale 1ns/1ps
module wavegen_timer_bench;

    localparam int NUM_CH = 4;
    localparam int CNT_W  = 8;

    // {pol[3:0], swap[1:0], expected wave[3:0]} in mode 3
    localparam logic [9:0] IDLE_VEC [0:7] = '{
        10'b0000_00_0000,
        10'b0101_00_0101,
        10'b0001_01_0100,
        10'b0010_10_1000,
        10'b0011_11_1100,
        10'b1001_11_0110,
        10'b1111_01_1111,
        10'b0110_01_0011
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    enable = 1'b0;
    logic [2:0]              mode = 3'd0;
    logic                    count_down = 1'b0;
    logic [NUM_CH-1:0]       pol = '0;
    logic                    circ_per_en = 1'b0;
    logic [NUM_CH-1:0]       circ_cc_en = '0;
    logic [NUM_CH/2-1:0]     swap_en = '0;
    logic                    per_buf_wr = 1'b0;
    logic [CNT_W-1:0]        per_buf_data = '0;
    logic [NUM_CH-1:0]       cc_buf_wr = '0;
    logic [NUM_CH*CNT_W-1:0] cc_buf_data = '0;
    logic [NUM_CH-1:0]       wave_o;
    logic                    ovf_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wavegen_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_wavegen_timer (
        .clk, .rst_n, .enable, .mode, .count_down, .pol, .circ_per_en,
        .circ_cc_en, .swap_en, .per_buf_wr, .per_buf_data, .cc_buf_wr,
        .cc_buf_data, .wave_o, .ovf_o
    );

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_pins(input string tag, input logic [3:0] w, input logic o);
        chk({tag, " wave"}, int'(wave_o), int'(w));
        chk({tag, " ovf"}, int'(ovf_o), int'(o));
    endtask

    // Mode 3 for one edge: counter held, channels forced to pol.
    task automatic park(input logic [3:0] p);
        mode = 3'd3;
        pol  = p;
        run(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit found;
        run(3);
        rst_n = 1'b1;
        run(1);
        chk_pins("R1 reset state", 4'b0000, 1'b0);

        // R10/R11 vector table in the parked mode
        mode = 3'd3;
        for (int i = 0; i < 8; i++) begin
            pol     = IDLE_VEC[i][9:6];
            swap_en = IDLE_VEC[i][5:4];
            run(1);
            chk($sformatf("R10 R11 vector %0d", i), int'(wave_o), int'(IDLE_VEC[i][3:0]));
        end
        pol     = '0;
        swap_en = '0;

        // load period 9 and compares ch0=2 ch1=5 ch2=9 ch3=0
        per_buf_data = 8'd9;
        cc_buf_data  = {8'd0, 8'd9, 8'd5, 8'd2};
        per_buf_wr   = 1'b1;
        cc_buf_wr    = 4'hF;
        run(1);
        per_buf_wr = 1'b0;
        cc_buf_wr  = '0;
        enable     = 1'b1;
        mode       = 3'd0;
        found      = 1'b0;
        for (int i = 0; i < 300 && !found; i++) begin
            run(1);
            if (ovf_o) found = 1'b1;
        end
        chk("R8 first update after full reset period", int'(found), 1);

        // Test A: normal frequency, top = period 9
        park(4'b0000);
        mode = 3'd0;
        run(3);  chk_pins("R3 toggle on match", 4'b1001, 1'b0);
        run(7);  chk_pins("R2 R4 wrap at period", 4'b1111, 1'b1);
        run(1);  chk_pins("R3 R4 after wrap", 4'b0111, 1'b0);

        // Test B: match frequency, top = compare 0 (=2)
        park(4'b0000);
        mode = 3'd1;
        run(2);  chk_pins("R2 top from compare 0", 4'b0001, 1'b1);
        run(1);  chk_pins("R3 toggle at zero", 4'b1001, 1'b0);
        run(2);  chk_pins("R2 second wrap", 4'b1000, 1'b1);

        // Test C: single-slope PWM counting up, ch1 polarity 1
        park(4'b0010);
        chk("R11 park level", int'(wave_o), 4'b0010);
        mode = 3'd2;
        run(10); chk_pins("R5 update start levels, update beats match", 4'b1101, 1'b1);
        run(3);  chk_pins("R5 match levels", 4'b0100, 1'b0);
        run(3);  chk_pins("R5 polarity 1 match", 4'b0110, 1'b0);
        run(4);  chk_pins("R5 next update", 4'b1101, 1'b1);

        // Test D: single-slope PWM counting down
        count_down = 1'b1;
        run(1);  chk_pins("R4 R5 down update at zero", 4'b0010, 1'b1);
        run(1);  chk_pins("R5 down match", 4'b0110, 1'b0);
        run(7);  chk_pins("R5 down matches", 4'b0101, 1'b0);
        run(2);  chk_pins("R4 down reload", 4'b0010, 1'b1);

        // Test E: dual slope, overflow at top only
        count_down = 1'b0;
        park(4'b0000);
        mode = 3'd7;
        run(1);  chk_pins("R6 R7 top turn", 4'b0100, 1'b1);
        run(9);  chk_pins("R7 no overflow at zero in mode 7", 4'b0100, 1'b0);
        run(2);  chk_pins("R6 match counting up", 4'b0101, 1'b0);
        run(3);  chk_pins("R6 second up match", 4'b0111, 1'b0);
        run(4);  chk_pins("R6 R7 top again", 4'b0111, 1'b1);

        // Test F: dual slope bottom with circular period, buffer 4
        mode         = 3'd5;
        circ_per_en  = 1'b1;
        per_buf_data = 8'd4;
        per_buf_wr   = 1'b1;
        run(1);
        per_buf_wr = 1'b0;
        run(8);  chk("R7 zero overflow mode 5", int'(ovf_o), 1);
        run(4);  chk("R7 no top overflow mode 5", int'(ovf_o), 0);
        run(4);  chk("R8 short period loaded", int'(ovf_o), 1);
        run(8);  chk("R9 period swapped back", int'(ovf_o), 0);
        run(1);  chk("R9 no top overflow", int'(ovf_o), 0);
        run(9);  chk("R9 long period restored", int'(ovf_o), 1);

        // Test G: compare buffer load and valid clear, period stays 4
        circ_per_en = 1'b0;
        cc_buf_data = {8'd0, 8'd0, 8'd3, 8'd0};
        cc_buf_wr   = 4'b0010;
        park(4'b0000);
        cc_buf_wr = '0;
        mode      = 3'd0;
        run(4);  chk_pins("R8 update with new compare", 4'b0001, 1'b1);
        run(4);  chk_pins("R8 compare 1 now 3", 4'b1010, 1'b0);
        run(6);  chk_pins("R8 invalid period not reloaded", 4'b0001, 1'b1);

        // Enable low holds everything
        enable = 1'b0;
        run(6);  chk_pins("R12 held while disabled", 4'b0001, 1'b0);
        enable = 1'b1;
        run(1);  chk_pins("R12 resumes from held count", 4'b1001, 1'b0);

        // Reset in the middle of a run
        rst_n = 1'b0;
        run(2);
        chk_pins("R1 reset during run", 4'b0000, 1'b0);
        rst_n = 1'b1;
        run(1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule